// File: doc/BRIEF.md
# Element-Width Polymorphic Vector Adder

This block runs one add instruction as a short inner loop over packed elements held in a small file of 64-bit registers. After a start pulse it freezes its operands and steps an element counter from 0 up to the vector length minus one, doing one element per clock. In each step it reads element `i` from two source register groups, using a source element width. It extends both elements and adds them at full precision. It then narrows the sum to the destination element width: it can wrap, clamp as unsigned or clamp as signed. The result is written back as element `i` of the destination group.

Elements are packed tightly from bit 0 of a base register. An element that starts at or beyond bit 64 lands in the following register, and register numbers wrap around the file. The source and destination widths are set independently. A flag records whether any element had to be clamped, when the caller asks for it. A load port and a read port give the surrounding logic access to the register file.

Top module: `ewva_vec_add`

## Requirements
- R1: An operation of length N (N > 0) accepted on a start pulse in idle writes one element per cycle. `done` is high for exactly one cycle, N+1 cycles after the start cycle.
- R2: Element i of width w occupies bits starting at i*w, counted from bit 0 of the base register. Bit positions at 64 and above fall into the following register numbers, taken modulo the register count.
- R3: An operation writes only the bytes of elements 0 to N-1. Every other destination bit keeps its value.
- R4: The add runs on extended operands without loss. With mode code 0 (wrap), the destination element receives the sum modulo 2^dw.
- R5: Mode code 1 (unsigned clamp) writes min(sum, 2^dw - 1).
- R6: Mode code 2 (signed clamp) clamps the sum into the range -2^(dw-1) to 2^(dw-1) - 1.
- R7: Width codes are 0=8, 1=16, 2=32 and 3=64 bits. A source element is sign-extended in mode 2 and zero-extended in modes 0 and 1.
- R8: `ovf` is cleared when an operation is accepted. It is set if `rc`=1 and any element was clamped, and it holds its value until the next accepted operation. With `rc`=0 it stays 0.
- R9: A length of 0 writes no register, raises `done` in the cycle after start and leaves `ovf` at 0.
- R10: After reset `done` and `ovf` are 0 and every register reads 0.
- R11: A load on the load port writes a full register while idle. A load issued during an operation is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| ra | input | AW | Base register of first source |
| rb | input | AW | Base register of second source |
| rt | input | AW | Base register of destination |
| src_ew | input | 2 | Source element width code |
| dst_ew | input | 2 | Destination element width code |
| vl | input | VL_W | Vector length |
| sat_mode | input | 2 | 0 wrap, 1 unsigned clamp, 2 signed clamp |
| rc | input | 1 | Enable overflow recording |
| ld_en | input | 1 | Register load strobe |
| ld_idx | input | AW | Register to load |
| ld_data | input | 64 | Load value |
| rd_idx | input | AW | Register to read |
| rd_data | output | 64 | Combinational read value |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Clamp-occurred flag |

## Verification
A table of operations covers every width pairing: equal widths, narrow sources with a wide destination, and a wide source with a narrow destination. Each runs under all three narrowing modes on pseudo-random register contents that cross register boundaries and wrap past the last register. An independent element loop model is compared against the whole register file, which separates packing mistakes from arithmetic mistakes. Hand-built directed cases hit both clamp edges in each direction, tell sign extension apart from zero extension, tell full-width addition apart from destination-width truncation, and check a zero length and a load issued while the block is busy.

// File: rtl/ewva_pkg.sv
package ewva_pkg;
    localparam int XLEN  = 64;
    localparam int SUMW  = XLEN + 2;
    localparam int LANES = XLEN / 8;

    typedef enum logic [1:0] {EW8 = 2'd0, EW16 = 2'd1, EW32 = 2'd2, EW64 = 2'd3} ew_e;
    typedef enum logic [1:0] {SAT_OFF = 2'd0, SAT_UNS = 2'd1, SAT_SGN = 2'd2, SAT_RSV = 2'd3} sat_e;

    typedef struct packed {
        ew_e  src_ew;
        ew_e  dst_ew;
        sat_e mode;
        logic rc;
    } op_cfg_t;

    typedef struct packed {
        logic [15:0] reg_adv;
        logic [5:0]  bit_off;
    } elem_loc_t;

    function automatic logic [6:0] ew_bits(ew_e w);
        return 7'd8 << w;
    endfunction

    function automatic elem_loc_t locate(logic [15:0] idx, ew_e w);
        logic [21:0] pos;
        elem_loc_t   loc;
        pos = {6'd0, idx} << (3 + int'(w));
        loc.reg_adv = pos[21:6];
        loc.bit_off = pos[5:0];
        return loc;
    endfunction

    function automatic logic [SUMW-1:0] widen(logic [XLEN-1:0] v, ew_e w, logic sgn);
        logic [6:0]      sh;
        logic [XLEN-1:0] up;
        logic [SUMW-1:0] t;
        sh = 7'd64 - ew_bits(w);
        up = v << sh;
        t  = {{2{sgn & up[XLEN-1]}}, up};
        if (sgn) return $signed(t) >>> sh;
        return t >> sh;
    endfunction

    function automatic logic [LANES-1:0] lane_mask(ew_e w, logic [5:0] off);
        logic [8:0]       wide;
        logic [LANES-1:0] base;
        wide = (9'd1 << (ew_bits(w) >> 3)) - 9'd1;
        base = wide[LANES-1:0];
        return base << off[5:3];
    endfunction
endpackage

// File: rtl/ewva_regfile.sv
module ewva_regfile
    import ewva_pkg::*;
#(
    parameter int NREGS = 16,
    localparam int AW = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    a_idx,
    input  logic [AW-1:0]    b_idx,
    output logic [XLEN-1:0]  a_word,
    output logic [XLEN-1:0]  b_word,
    input  logic             el_we,
    input  logic [AW-1:0]    el_idx,
    input  logic [XLEN-1:0]  el_data,
    input  logic [LANES-1:0] el_mask,
    input  logic             ld_we,
    input  logic [AW-1:0]    ld_idx,
    input  logic [XLEN-1:0]  ld_data,
    input  logic [AW-1:0]    rd_idx,
    output logic [XLEN-1:0]  rd_data
);
    logic [XLEN-1:0] mem [NREGS];

    assign a_word  = mem[a_idx];
    assign b_word  = mem[b_idx];
    assign rd_data = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREGS; r++) mem[r] <= '0;
        end else begin
            for (int r = 0; r < NREGS; r++) begin
                for (int b = 0; b < LANES; b++) begin
                    if (el_we && el_idx == AW'(r) && el_mask[b])
                        mem[r][8*b +: 8] <= el_data[8*b +: 8];
                    else if (ld_we && ld_idx == AW'(r))
                        mem[r][8*b +: 8] <= ld_data[8*b +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/ewva_elem_alu.sv
module ewva_elem_alu
    import ewva_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  op_cfg_t          cfg,
    input  logic [XLEN-1:0]  a_word,
    input  logic [XLEN-1:0]  b_word,
    input  logic [5:0]       a_off,
    input  logic [5:0]       b_off,
    input  logic [5:0]       d_off,
    output logic [XLEN-1:0]  wdata,
    output logic [LANES-1:0] wmask,
    output logic             sat_hit
);
    logic signed [SUMW-1:0] ea, eb, sum, res, umax, smax, smin, one;
    logic [6:0]             dw;
    logic                   sgn;
    logic [XLEN-1:0]        trunc;

    always_comb begin
        sgn  = (cfg.mode == SAT_SGN);
        ea   = widen(a_word >> a_off, cfg.src_ew, sgn);
        eb   = widen(b_word >> b_off, cfg.src_ew, sgn);
        sum  = ea + eb;
        dw   = ew_bits(cfg.dst_ew);
        one  = SUMW'(1);
        umax = (one << dw) - one;
        smax = (one << (dw - 7'd1)) - one;
        smin = -(one << (dw - 7'd1));
        res  = sum;
        sat_hit = 1'b0;
        case (cfg.mode)
            SAT_UNS: if (sum > umax) begin
                res = umax;
                sat_hit = 1'b1;
            end
            SAT_SGN: begin
                if (sum > smax) begin
                    res = smax;
                    sat_hit = 1'b1;
                end else if (sum < smin) begin
                    res = smin;
                    sat_hit = 1'b1;
                end
            end
            default: res = sum;
        endcase
        trunc = res[XLEN-1:0] & umax[XLEN-1:0];
        wdata = trunc << d_off;
        wmask = lane_mask(cfg.dst_ew, d_off);
    end

    // R5: unsigned clamp never exceeds the destination maximum
    assert_uns_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (valid && cfg.mode == SAT_UNS) |-> (res <= umax));

    // R6: signed clamp stays inside the destination range
    assert_sgn_bound_R6: assert property (@(posedge clk) disable iff (rst)
        (valid && cfg.mode == SAT_SGN) |-> (res <= smax && res >= smin));
endmodule

// File: rtl/ewva_seq.sv
module ewva_seq
    import ewva_pkg::*;
#(
    parameter int VL_W = 6,
    parameter int AW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [VL_W-1:0] vl_in,
    input  op_cfg_t         cfg_in,
    input  logic [AW-1:0]   ra_in,
    input  logic [AW-1:0]   rb_in,
    input  logic [AW-1:0]   rt_in,
    input  logic            sat_hit,
    output logic            busy,
    output logic            elem_we,
    output logic [VL_W-1:0] idx,
    output op_cfg_t         cfg_q,
    output logic [AW-1:0]   ra_q,
    output logic [AW-1:0]   rb_q,
    output logic [AW-1:0]   rt_q,
    output logic            done,
    output logic            ovf
);
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} st_e;
    st_e             state;
    logic [VL_W-1:0] vl_q;

    assign busy    = (state != ST_IDLE);
    assign elem_we = (state == ST_RUN);
    assign done    = (state == ST_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
            vl_q  <= '0;
            cfg_q <= '0;
            ra_q  <= '0;
            rb_q  <= '0;
            rt_q  <= '0;
            ovf   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    idx   <= '0;
                    vl_q  <= vl_in;
                    cfg_q <= cfg_in;
                    ra_q  <= ra_in;
                    rb_q  <= rb_in;
                    rt_q  <= rt_in;
                    ovf   <= 1'b0;
                    state <= (vl_in == '0) ? ST_FIN : ST_RUN;
                end
                ST_RUN: begin
                    if (sat_hit && cfg_q.rc) ovf <= 1'b1;
                    idx <= idx + VL_W'(1);
                    if (idx == vl_q - VL_W'(1)) state <= ST_FIN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: completion is a single-cycle pulse
    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1: the element counter never reaches the vector length while writing
    assert_idx_bound_R1: assert property (@(posedge clk) disable iff (rst)
        elem_we |-> (idx < vl_q));

    // R9: zero length finishes on the next cycle with a clear flag
    assert_zero_len_R9: assert property (@(posedge clk) disable iff (rst)
        (start && state == ST_IDLE && vl_in == '0) |=> (done && !ovf && !elem_we));

    // R8: without rc the flag never rises
    assert_ovf_gate_R8: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.rc |-> !ovf);
endmodule

// File: rtl/ewva_vec_add.sv
module ewva_vec_add
    import ewva_pkg::*;
#(
    parameter int NREGS = 16,
    parameter int VL_W = 6,
    localparam int AW = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [AW-1:0]   ra,
    input  logic [AW-1:0]   rb,
    input  logic [AW-1:0]   rt,
    input  logic [1:0]      src_ew,
    input  logic [1:0]      dst_ew,
    input  logic [VL_W-1:0] vl,
    input  logic [1:0]      sat_mode,
    input  logic            rc,
    input  logic            ld_en,
    input  logic [AW-1:0]   ld_idx,
    input  logic [63:0]     ld_data,
    input  logic [AW-1:0]   rd_idx,
    output logic [63:0]     rd_data,
    output logic            done,
    output logic            ovf
);
    op_cfg_t          cfg_in, cfg_q;
    logic             busy, elem_we, sat_hit;
    logic [VL_W-1:0]  idx;
    logic [AW-1:0]    ra_q, rb_q, rt_q;
    logic [AW-1:0]    a_idx, b_idx, d_idx;
    elem_loc_t        s_loc, d_loc;
    logic [XLEN-1:0]  a_word, b_word, wdata;
    logic [LANES-1:0] wmask;

    always_comb begin
        cfg_in.src_ew = ew_e'(src_ew);
        cfg_in.dst_ew = ew_e'(dst_ew);
        cfg_in.mode   = sat_e'(sat_mode);
        cfg_in.rc     = rc;
        s_loc = locate(16'(idx), cfg_q.src_ew);
        d_loc = locate(16'(idx), cfg_q.dst_ew);
        a_idx = ra_q + s_loc.reg_adv[AW-1:0];
        b_idx = rb_q + s_loc.reg_adv[AW-1:0];
        d_idx = rt_q + d_loc.reg_adv[AW-1:0];
    end

    ewva_seq #(.VL_W(VL_W), .AW(AW)) u_seq (
        .clk(clk), .rst(rst), .start(start), .vl_in(vl), .cfg_in(cfg_in),
        .ra_in(ra), .rb_in(rb), .rt_in(rt), .sat_hit(sat_hit),
        .busy(busy), .elem_we(elem_we), .idx(idx), .cfg_q(cfg_q),
        .ra_q(ra_q), .rb_q(rb_q), .rt_q(rt_q), .done(done), .ovf(ovf)
    );

    ewva_elem_alu u_alu (
        .clk(clk), .rst(rst), .valid(elem_we), .cfg(cfg_q),
        .a_word(a_word), .b_word(b_word),
        .a_off(s_loc.bit_off), .b_off(s_loc.bit_off), .d_off(d_loc.bit_off),
        .wdata(wdata), .wmask(wmask), .sat_hit(sat_hit)
    );

    ewva_regfile #(.NREGS(NREGS)) u_rf (
        .clk(clk), .rst(rst),
        .a_idx(a_idx), .b_idx(b_idx), .a_word(a_word), .b_word(b_word),
        .el_we(elem_we), .el_idx(d_idx), .el_data(wdata), .el_mask(wmask),
        .ld_we(ld_en && !busy), .ld_idx(ld_idx), .ld_data(ld_data),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );
endmodule

// File: tb/sim_ewva_vec_add.sv
module sim_ewva_vec_add;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  ra = '0, rb = '0, rt = '0, ld_idx = '0, rd_idx = '0;
    logic [1:0]  src_ew = '0, dst_ew = '0, sat_mode = '0;
    logic [5:0]  vl = '0;
    logic        rc = 1'b0, ld_en = 1'b0;
    logic [63:0] ld_data = '0, rd_data;
    logic        done, ovf;

    int checks = 0;
    int fails  = 0;
    logic [63:0] mirror [16];

    always #10 clk = ~clk;

    ewva_vec_add u0 (
        .clk(clk), .rst(rst), .start(start), .ra(ra), .rb(rb), .rt(rt),
        .src_ew(src_ew), .dst_ew(dst_ew), .vl(vl), .sat_mode(sat_mode), .rc(rc),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .done(done), .ovf(ovf)
    );

    // fields: ra rb rt src_code dst_code len mode rc
    localparam logic [63:0] VECS [8] = '{
        {8'd1, 8'd2, 8'd3, 8'd0, 8'd0, 8'd8, 8'd0, 8'd1},
        {8'd4, 8'd5, 8'd6, 8'd1, 8'd1, 8'd4, 8'd1, 8'd1},
        {8'd7, 8'd8, 8'd9, 8'd2, 8'd2, 8'd2, 8'd2, 8'd1},
        {8'd10, 8'd11, 8'd12, 8'd3, 8'd3, 8'd2, 8'd1, 8'd1},
        {8'd0, 8'd1, 8'd14, 8'd0, 8'd1, 8'd8, 8'd2, 8'd1},
        {8'd2, 8'd3, 8'd15, 8'd3, 8'd3, 8'd2, 8'd2, 8'd0},
        {8'd5, 8'd5, 8'd8, 8'd1, 8'd2, 8'd5, 8'd1, 8'd1},
        {8'd6, 8'd7, 8'd4, 8'd3, 8'd0, 8'd11, 8'd0, 8'd0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] get_el(int base, int w, int i);
        int pos = i * w;
        logic [63:0] v = mirror[(base + pos / 64) % 16] >> (pos % 64);
        if (w < 64) v = v & ((64'd1 << w) - 64'd1);
        return v;
    endfunction

    task automatic model(input int a_r, input int b_r, input int t_r, input int swc,
                         input int dwc, input int len, input int mode, input int rcv,
                         output bit eovf);
        int sw = 8 << swc;
        int dw = 8 << dwc;
        eovf = 1'b0;
        for (int i = 0; i < len; i++) begin
            logic [63:0] a = get_el(a_r, sw, i);
            logic [63:0] b = get_el(b_r, sw, i);
            logic signed [67:0] ea = $signed({4'b0, a});
            logic signed [67:0] eb = $signed({4'b0, b});
            logic signed [67:0] s, umax, smax, smin;
            logic [63:0] m;
            bit hit = 1'b0;
            int pos = i * dw;
            int r = (t_r + pos / 64) % 16;
            if (mode == 2 && a[sw-1]) ea = ea - (68'sd1 <<< sw);
            if (mode == 2 && b[sw-1]) eb = eb - (68'sd1 <<< sw);
            s    = ea + eb;
            umax = (68'sd1 <<< dw) - 68'sd1;
            smax = (68'sd1 <<< (dw - 1)) - 68'sd1;
            smin = -(68'sd1 <<< (dw - 1));
            if (mode == 1 && s > umax) begin s = umax; hit = 1'b1; end
            if (mode == 2 && s > smax) begin s = smax; hit = 1'b1; end
            if (mode == 2 && s < smin) begin s = smin; hit = 1'b1; end
            m = (dw == 64) ? '1 : ((64'd1 << dw) - 64'd1);
            mirror[r] = (mirror[r] & ~(m << (pos % 64))) | ((s[63:0] & m) << (pos % 64));
            if (hit && rcv != 0) eovf = 1'b1;
        end
    endtask

    task automatic load(input int idx, input logic [63:0] data);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 4'(idx); ld_data = data;
        @(negedge clk);
        ld_en = 1'b0;
        mirror[idx] = data;
    endtask

    task automatic compare_regs(input string req);
        for (int k = 0; k < 16; k++) begin
            rd_idx = 4'(k);
            #1;
            check(rd_data === mirror[k], req, $sformatf("reg%0d", k), rd_data, mirror[k]);
        end
    endtask

    task automatic run_op(input int a_r, input int b_r, input int t_r, input int swc,
                          input int dwc, input int len, input int mode, input int rcv,
                          input bit poke, input string req);
        bit eovf;
        int cyc;
        model(a_r, b_r, t_r, swc, dwc, len, mode, rcv, eovf);
        @(negedge clk);
        ra = 4'(a_r); rb = 4'(b_r); rt = 4'(t_r);
        src_ew = 2'(swc); dst_ew = 2'(dwc); vl = 6'(len);
        sat_mode = 2'(mode); rc = rcv[0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        if (poke) begin
            ld_en = 1'b1; ld_idx = 4'd9; ld_data = 64'hDEAD_BEEF_0BAD_F00D;
        end
        while (!done && cyc < 300) begin
            @(negedge clk);
            ld_en = 1'b0;
            cyc++;
        end
        ld_en = 1'b0;
        check(cyc == len + 1, "R1", "done latency", 64'(cyc), 64'(len + 1));
        check(ovf == eovf, req, "ovf", {63'd0, ovf}, {63'd0, eovf});
        @(negedge clk);
        check(!done, "R1", "done width", {63'd0, done}, 64'd0);
        compare_regs(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) mirror[k] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        check(!done && !ovf, "R10", "done/ovf after reset", {62'd0, done, ovf}, 64'd0);
        compare_regs("R10");

        // R11: idle loads
        for (int k = 0; k < 16; k++) load(k, 64'(k + 1) * 64'h9E37_79B9_7F4A_7C15);
        compare_regs("R11");

        // table walk: R2 R3 R4 R5 R6 R7 R8 via the element model
        for (int v = 0; v < 8; v++) begin
            run_op(int'(VECS[v][63:56]), int'(VECS[v][55:48]), int'(VECS[v][47:40]),
                   int'(VECS[v][39:32]), int'(VECS[v][31:24]), int'(VECS[v][23:16]),
                   int'(VECS[v][15:8]), int'(VECS[v][7:0]), 1'b0, "R2/R3/R4/R5/R6/R7/R8");
        end

        // R2 R3: 16-bit, length 3 fills bits 0..47 only
        load(1, 64'h1111_2222_3333_4444);
        load(2, 64'h0001_0001_0001_0001);
        load(3, 64'hAAAA_BBBB_CCCC_DDDD);
        run_op(1, 2, 3, 1, 1, 3, 0, 0, 1'b0, "R3");
        rd_idx = 4'd3; #1;
        check(rd_data == 64'hAAAA_2223_3334_4445, "R2", "packed 16-bit", rd_data, 64'hAAAA_2223_3334_4445);

        // R5: unsigned clamp with and without rc
        load(1, 64'h80FF);
        load(2, 64'h8001);
        run_op(1, 2, 3, 0, 0, 2, 1, 1, 1'b0, "R5");
        rd_idx = 4'd3; #1;
        check(rd_data == 64'hAAAA_2223_3334_FFFF, "R5", "unsigned clamp", rd_data, 64'hAAAA_2223_3334_FFFF);
        check(ovf == 1'b1, "R8", "ovf set with rc", {63'd0, ovf}, 64'd1);
        run_op(1, 2, 3, 0, 0, 2, 1, 0, 1'b0, "R8");
        check(ovf == 1'b0, "R8", "ovf clear without rc", {63'd0, ovf}, 64'd0);

        // R6: signed clamp at both ends
        load(1, 64'h7F80);
        load(2, 64'h01FF);
        run_op(1, 2, 3, 0, 0, 2, 2, 1, 1'b0, "R6");
        rd_idx = 4'd3; #1;
        check(rd_data[15:0] == 16'h7F80, "R6", "signed clamp", {48'd0, rd_data[15:0]}, 64'h7F80);

        // R7 / R4: 8-bit source into 16-bit destination
        load(1, 64'hFF);
        load(2, 64'h01);
        run_op(1, 2, 3, 0, 1, 1, 0, 0, 1'b0, "R7");
        rd_idx = 4'd3; #1;
        check(rd_data[15:0] == 16'h0100, "R7", "zero extend, full add", {48'd0, rd_data[15:0]}, 64'h0100);
        run_op(1, 2, 3, 0, 1, 1, 2, 1, 1'b0, "R7");
        rd_idx = 4'd3; #1;
        check(rd_data[15:0] == 16'h0000, "R7", "sign extend", {48'd0, rd_data[15:0]}, 64'h0);
        load(2, 64'hFF);
        run_op(1, 2, 3, 0, 1, 1, 0, 0, 1'b0, "R4");
        rd_idx = 4'd3; #1;
        check(rd_data[15:0] == 16'h01FE, "R4", "no narrowing before add", {48'd0, rd_data[15:0]}, 64'h01FE);

        // R9: zero length after a flagged run
        run_op(1, 2, 3, 0, 0, 2, 1, 1, 1'b0, "R8");
        run_op(1, 2, 3, 0, 0, 0, 1, 1, 1'b0, "R9");
        check(ovf == 1'b0, "R9", "flag after zero length", {63'd0, ovf}, 64'd0);

        // R11: load while busy is dropped
        run_op(1, 2, 4, 3, 3, 4, 0, 0, 1'b1, "R11");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule